// File: doc/BRIEF.md
# Shared-RAM Host Slave Port

This block lets a 16-bit host processor read and write an on-chip shared RAM and a small register file. The host uses a select, a strobe, a read/write line, a 16-bit address and 16-bit write and read data buses. An internal agent also uses the RAM through a single-cycle request/grant port, and it always wins a conflict. The block has one RAM port, so host traffic and internal traffic take turns on it.

Two static straps set how the block looks to the host. The first strap sets the sense of the read/write line. The second strap chooses the handshake style:

- **Acknowledge style.** The ready line rests high. It drops low once a write has been committed, or once read data is valid on the bus. It stays low for as long as the host keeps its strobe asserted.
- **Zero-wait style.** The ready line rests low and rises as soon as a strobe is taken. The host may drop its strobe at once. The block has already captured the address, data and direction, and ready falls again when the transfer is done.

Addresses with either of the two top bits set select the register file; all other addresses fall in a 16K-word RAM window. The RAM array is smaller by default and repeats across that window.

Top module: `shram_host_port`

## Requirements
- R1: With `strapWrHigh`=1, `hostRdWr`=1 requests a write and 0 a read. With `strapWrHigh`=0 the sense is inverted.
- R2: With `strapAck`=1, `hostReady` rests high. It goes low 2 clock edges after the strobe is taken for a register access or a RAM write, and 3 edges after for a RAM read. At that point a write is already committed, or read data is driven with `hostRdataEn`=1. It stays low while the strobe is held and returns high on the first edge that sees the strobe low.
- R3: With `strapAck`=0, `hostReady` rests low. It is high on the cycle after a strobe is taken and returns low when the transfer completes. After a read it holds the data on `hostRdata` with `hostRdataEn`=1.
- R4: In zero-wait style, the address, write data and direction are captured when the strobe is taken. Changes to those inputs after that point do not affect the transfer.
- R5: An address with bit 15 or bit 14 set selects one of four 16-bit registers by address bits 1:0; bits 13:2 are ignored. Registers reset to 0.
- R6: When `intReq` is high, the RAM port serves the internal agent (`intGnt`=1) and a host RAM access waits. An internal write commits on that edge. An internal read returns data on `intRdata` after that edge.
- R7: A strobe raised while a zero-wait transfer is still busy is stalled. It is taken only after `hostReady` has returned low, and then it completes normally.
- R8: Reset drops any pending transfer, drives `hostReady` to its resting level for the current `strapAck`, and clears `hostRdataEn`.
- R9: A strobe with `hostSel` low is ignored: no transfer starts and the register contents are unchanged.
- R10: An address with bits 15:14 both clear reaches RAM word `addr mod 2^RamAw`. The default RamAw is 12, so 0x1005 and 0x0005 name the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strapAck | input | 1 | Handshake style: 1 acknowledge, 0 zero-wait (static) |
| strapWrHigh | input | 1 | Read/write sense: 1 means high is write (static) |
| hostSel | input | 1 | Host select, active high |
| hostStrb | input | 1 | Host strobe, active high |
| hostRdWr | input | 1 | Host read/write line, sense set by strapWrHigh |
| hostAddr | input | 16 | Host word address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data |
| hostRdataEn | output | 1 | Read data valid / bus drive enable |
| hostReady | output | 1 | Handshake line, meaning set by strapAck |
| intReq | input | 1 | Internal agent RAM request |
| intGnt | output | 1 | Internal agent grant |
| intWe | input | 1 | Internal agent write enable |
| intAddr | input | RamAw (12) | Internal agent RAM address |
| intWdata | input | 16 | Internal agent write data |
| intRdata | output | 16 | Internal agent read data, valid the cycle after a grant |

## Verification
The bench measures the acknowledge latency for register, RAM-write and RAM-read accesses, and the exact cycle at which ready rises in zero-wait style. A design that signalled early would hand the host stale read data. In zero-wait style the bench scrambles the address, data and direction right after the strobe, and a design that did not latch them would write to the wrong place or in the wrong direction. Further cases:

- A host RAM write is held off by a busy internal agent; wrong arbitration would let the host's value be overwritten or lost.
- A second strobe is raised during a busy transfer; a design that ignored the stall would drop it or corrupt the first transfer.
- Accesses are made under both read/write polarities, through the upper-address register decode, and through an aliased RAM address.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REGX,
    ST_RAMREQ,
    ST_RAMRD,
    ST_HOLD
  } hrpState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture address, data and direction
    logic regWr;    // write latched data into register file
    logic regRd;    // load read register from register file
    logic ramHost;  // host owns the RAM port this cycle
    logic capRam;   // load read register from RAM output
  } hrpCtl_t;

endpackage

// File: rtl/hrp_ram.sv
module hrp_ram #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem [Depth];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end
endmodule

// File: rtl/hrp_datapath.sv
module hrp_datapath
  import hrp_pkg::*;
#(
  parameter int DataW   = 16,
  parameter int AddrW   = 16,
  parameter int WinAw   = 14,
  parameter int RamAw   = 12,
  parameter int NumRegs = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapWrHigh,
  input  logic             hostRdWr,
  input  logic [AddrW-1:0] hostAddr,
  input  logic [DataW-1:0] hostWdata,
  input  hrpCtl_t          ctl,
  input  logic             intReq,
  input  logic             intWe,
  input  logic [RamAw-1:0] intAddr,
  input  logic [DataW-1:0] intWdata,
  output logic             liveIsReg,
  output logic             latWrite,
  output logic [DataW-1:0] hostRdata,
  output logic [DataW-1:0] intRdata
);
  localparam int RegIdxW = (NumRegs > 1) ? $clog2(NumRegs) : 1;

  logic [AddrW-1:0] latAddr;
  logic [DataW-1:0] latData;
  logic             latWriteQ;
  logic [DataW-1:0] rdataQ;
  logic [DataW-1:0] regFile [NumRegs];
  logic [RegIdxW-1:0] regIdx;
  logic             ramEn;
  logic             ramWe;
  logic [RamAw-1:0] ramAddr;
  logic [DataW-1:0] ramWdata;
  logic [DataW-1:0] ramQ;

  assign liveIsReg = |hostAddr[AddrW-1:WinAw];
  assign latWrite  = latWriteQ;
  assign regIdx    = latAddr[RegIdxW-1:0];

  // Capture of the host request when the strobe is taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr   <= '0;
      latData   <= '0;
      latWriteQ <= 1'b0;
    end else if (ctl.latch) begin
      latAddr   <= hostAddr;
      latData   <= hostWdata;
      latWriteQ <= strapWrHigh ? hostRdWr : !hostRdWr;
    end
  end

  // Register file
  for (genvar g = 0; g < NumRegs; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       regFile[g] <= '0;
      else if (ctl.regWr && regIdx == RegIdxW'(g))     regFile[g] <= latData;
    end
  end

  // RAM port shared with internal agent; internal side has priority
  assign ramEn    = intReq | ctl.ramHost;
  assign ramWe    = intReq ? intWe : latWriteQ;
  assign ramAddr  = intReq ? intAddr : latAddr[RamAw-1:0];
  assign ramWdata = intReq ? intWdata : latData;

  hrp_ram #(.AW(RamAw), .DW(DataW)) uRam (
    .clk  (clk),
    .en   (ramEn),
    .we   (ramWe),
    .addr (ramAddr),
    .wdata(ramWdata),
    .q    (ramQ)
  );

  assign intRdata = ramQ;

  // Host read data holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdataQ <= '0;
    else if (ctl.regRd)   rdataQ <= regFile[regIdx];
    else if (ctl.capRam)  rdataQ <= ramQ;
  end

  assign hostRdata = rdataQ;

  AST_REG_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWr || ctl.regRd) |-> (|latAddr[AddrW-1:WinAw])); // R5

  AST_RAM_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ramHost |-> !(|latAddr[AddrW-1:WinAw])); // R10

endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    strapAck,
  input  logic    hostSel,
  input  logic    hostStrb,
  input  logic    intReq,
  input  logic    liveIsReg,
  input  logic    latWrite,
  output hrpCtl_t ctl,
  output logic    hostReady,
  output logic    hostRdataEn,
  output logic    intGnt
);
  hrpState_e state, stateNxt;
  logic armed;
  logic lastRead;
  logic accept;
  logic done;

  // A strobe is taken only from idle, and only if it is fresh
  assign accept = (state == ST_IDLE) && hostSel && hostStrb && armed;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          ctl.latch = 1'b1;
          stateNxt  = liveIsReg ? ST_REGX : ST_RAMREQ;
        end
      end
      ST_REGX: begin
        ctl.regWr = latWrite;
        ctl.regRd = !latWrite;
        done      = 1'b1;
      end
      ST_RAMREQ: begin
        if (!intReq) begin
          ctl.ramHost = 1'b1;
          if (latWrite) done = 1'b1;
          else          stateNxt = ST_RAMRD;
        end
      end
      ST_RAMRD: begin
        ctl.capRam = 1'b1;
        done       = 1'b1;
      end
      ST_HOLD: begin
        if (!hostStrb) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (done) stateNxt = strapAck ? ST_HOLD : ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b1;
      lastRead <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept)         armed <= 1'b0;
      else if (!hostStrb) armed <= 1'b1;
      if (accept)         lastRead <= 1'b0;
      else if (done)      lastRead <= !latWrite;
    end
  end

  assign hostReady   = strapAck ? (state != ST_HOLD) : (state != ST_IDLE);
  assign hostRdataEn = lastRead && (strapAck ? (state == ST_HOLD) : (state == ST_IDLE));
  assign intGnt      = intReq;

  AST_INT_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> !ctl.ramHost); // R6

  AST_ZW_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!strapAck && ctl.latch) |=> hostReady); // R3

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strapAck && !hostReady && hostStrb) |=> !hostReady); // R2

  AST_SEL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !hostSel) |=> !$rose(hostReady ^ strapAck)); // R9

  AST_NO_LATCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!strapAck && hostReady) |=> !$past(ctl.latch) || hostReady); // R7

endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
  import hrp_pkg::*;
#(
  parameter int DataW   = 16,
  parameter int AddrW   = 16,
  parameter int WinAw   = 14,
  parameter int RamAw   = 12,
  parameter int NumRegs = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapAck,
  input  logic             strapWrHigh,
  input  logic             hostSel,
  input  logic             hostStrb,
  input  logic             hostRdWr,
  input  logic [AddrW-1:0] hostAddr,
  input  logic [DataW-1:0] hostWdata,
  output logic [DataW-1:0] hostRdata,
  output logic             hostRdataEn,
  output logic             hostReady,
  input  logic             intReq,
  output logic             intGnt,
  input  logic             intWe,
  input  logic [RamAw-1:0] intAddr,
  input  logic [DataW-1:0] intWdata,
  output logic [DataW-1:0] intRdata
);
  hrpCtl_t ctl;
  logic    liveIsReg;
  logic    latWrite;

  hrp_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .strapAck   (strapAck),
    .hostSel    (hostSel),
    .hostStrb   (hostStrb),
    .intReq     (intReq),
    .liveIsReg  (liveIsReg),
    .latWrite   (latWrite),
    .ctl        (ctl),
    .hostReady  (hostReady),
    .hostRdataEn(hostRdataEn),
    .intGnt     (intGnt)
  );

  hrp_datapath #(
    .DataW  (DataW),
    .AddrW  (AddrW),
    .WinAw  (WinAw),
    .RamAw  (RamAw),
    .NumRegs(NumRegs)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strapWrHigh(strapWrHigh),
    .hostRdWr   (hostRdWr),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .ctl        (ctl),
    .intReq     (intReq),
    .intWe      (intWe),
    .intAddr    (intAddr),
    .intWdata   (intWdata),
    .liveIsReg  (liveIsReg),
    .latWrite   (latWrite),
    .hostRdata  (hostRdata),
    .intRdata   (intRdata)
  );
endmodule

// File: tb/tb_shram_host_port.sv
`timescale 1ns/1ps
module tb_shram_host_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapAck = 1'b1;
  logic        strapWrHigh = 1'b1;
  logic        hostSel = 1'b0;
  logic        hostStrb = 1'b0;
  logic        hostRdWr = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostRdataEn;
  logic        hostReady;
  logic        intReq = 1'b0;
  logic        intGnt;
  logic        intWe = 1'b0;
  logic [11:0] intAddr = '0;
  logic [15:0] intWdata = '0;
  logic [15:0] intRdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shram_host_port dut (
    .clk(clk), .rstN(rstN), .strapAck(strapAck), .strapWrHigh(strapWrHigh),
    .hostSel(hostSel), .hostStrb(hostStrb), .hostRdWr(hostRdWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRdataEn(hostRdataEn), .hostReady(hostReady), .intReq(intReq),
    .intGnt(intGnt), .intWe(intWe), .intAddr(intAddr), .intWdata(intWdata),
    .intRdata(intRdata)
  );

  typedef struct packed {
    logic        ack;
    logic        wrHigh;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam int NumVec = 12;
  localparam vec_t Vecs [NumVec] = '{
    '{1'b1, 1'b1, 1'b1, 16'h0010, 16'hA5A5, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 16'h4002, 16'h1234, 16'h0000},
    '{1'b1, 1'b1, 1'b0, 16'h0010, 16'h0000, 16'hA5A5},
    '{1'b1, 1'b1, 1'b0, 16'h4002, 16'h0000, 16'h1234},
    '{1'b1, 1'b0, 1'b1, 16'h1005, 16'hBEEF, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 16'h0005, 16'h0000, 16'hBEEF},
    '{1'b1, 1'b0, 1'b0, 16'hC002, 16'h0000, 16'h0000},
    '{1'b0, 1'b1, 1'b1, 16'h8001, 16'h5A5A, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 16'h4001, 16'h0000, 16'h5A5A},
    '{1'b0, 1'b1, 1'b1, 16'h0020, 16'h0F0F, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 16'h0020, 16'h0000, 16'h0F0F},
    '{1'b0, 1'b1, 1'b0, 16'h1005, 16'h0000, 16'hBEEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic ack, input logic wrHigh);
    @(negedge clk);
    strapAck = ack; strapWrHigh = wrHigh; rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 ready level in reset", 32'(hostReady), 32'(ack));
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 ready level after reset", 32'(hostReady), 32'(ack));
    chk("R8 no read data after reset", 32'(hostRdataEn), 32'd0);
  endtask

  // Acknowledge-style access; latency counted in falling edges until ready low
  task automatic ackAccess(input logic wr, input logic [15:0] a, input logic [15:0] d,
                           output logic [15:0] rd, output logic en, output int lat);
    @(negedge clk);
    hostSel = 1'b1; hostStrb = 1'b1; hostRdWr = wr ? strapWrHigh : !strapWrHigh;
    hostAddr = a; hostWdata = d; lat = 0;
    do begin @(negedge clk); lat++; end while (hostReady && lat < 50);
    rd = hostRdata; en = hostRdataEn;
    hostStrb = 1'b0; hostSel = 1'b0;
    @(negedge clk);
    chk("R2 ready returns high after strobe drop", 32'(hostReady), 32'd1);
  endtask

  // Zero-wait access; strobe is a one-cycle pulse, inputs scrambled after it
  task automatic zwAccess(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output logic en, output int lat);
    @(negedge clk);
    hostSel = 1'b1; hostStrb = 1'b1; hostRdWr = wr ? strapWrHigh : !strapWrHigh;
    hostAddr = a; hostWdata = d; lat = 1;
    @(negedge clk);
    chk("R3 ready high after strobe taken", 32'(hostReady), 32'd1);
    hostStrb = 1'b0; hostSel = 1'b0;
    hostAddr = ~a; hostWdata = ~d; hostRdWr = ~hostRdWr;   // R4 scramble
    while (hostReady && lat < 50) begin @(negedge clk); lat++; end
    rd = hostRdata; en = hostRdataEn;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    logic en;
    int lat;
    int expLat;
    logic curAck;
    logic curPol;

    curAck = 1'b0; curPol = 1'b0;

    // Table walk: R1 polarity, R2/R3 handshake, R4 latching, R5 decode, R10 alias
    for (int i = 0; i < NumVec; i++) begin
      if (i == 0 || Vecs[i].ack != curAck || Vecs[i].wrHigh != curPol) begin
        curAck = Vecs[i].ack; curPol = Vecs[i].wrHigh;
        doReset(curAck, curPol);
      end
      expLat = (|Vecs[i].addr[15:14]) ? 2 : (Vecs[i].wr ? 2 : 3);
      if (curAck) ackAccess(Vecs[i].wr, Vecs[i].addr, Vecs[i].data, rd, en, lat);
      else        zwAccess(Vecs[i].wr, Vecs[i].addr, Vecs[i].data, rd, en, lat);
      chk(curAck ? "R2 ack latency" : "R3 busy duration", 32'(lat), 32'(expLat));
      if (!Vecs[i].wr) begin
        chk("R1 R5 R10 read data", 32'(rd), 32'(Vecs[i].exp));
        chk(curAck ? "R2 read data enable" : "R3 read data held", 32'(en), 32'd1);
      end
    end

    // R9: strobe without select is ignored
    doReset(1'b1, 1'b1);
    @(negedge clk);
    hostSel = 1'b0; hostStrb = 1'b1; hostRdWr = 1'b1; hostAddr = 16'h4003; hostWdata = 16'hFFFF;
    repeat (4) @(negedge clk);
    chk("R9 ready stays idle without select", 32'(hostReady), 32'd1);
    hostStrb = 1'b0;
    ackAccess(1'b0, 16'h4003, 16'h0000, rd, en, lat);
    chk("R9 register unchanged", 32'(rd), 32'h0000);

    // R2: ready held low while strobe held
    @(negedge clk);
    hostSel = 1'b1; hostStrb = 1'b1; hostRdWr = 1'b1; hostAddr = 16'h4003; hostWdata = 16'h3333;
    lat = 0;
    do begin @(negedge clk); lat++; end while (hostReady && lat < 50);
    repeat (3) @(negedge clk);
    chk("R2 ready low while strobe held", 32'(hostReady), 32'd0);
    hostStrb = 1'b0; hostSel = 1'b0;
    @(negedge clk);
    chk("R2 ready high after release", 32'(hostReady), 32'd1);

    // R6: internal agent has priority over a host RAM write
    intReq = 1'b1; intWe = 1'b1; intAddr = 12'h007; intWdata = 16'h1111;
    hostSel = 1'b1; hostStrb = 1'b1; hostRdWr = 1'b1; hostAddr = 16'h0007; hostWdata = 16'h2222;
    @(negedge clk);
    chk("R6 internal grant", 32'(intGnt), 32'd1);
    repeat (3) @(negedge clk);
    chk("R6 host waits during internal request", 32'(hostReady), 32'd1);
    intReq = 1'b0; intWe = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (hostReady && lat < 50);
    chk("R6 host write completes after release", 32'(lat), 32'd1);
    hostStrb = 1'b0; hostSel = 1'b0;
    @(negedge clk);
    intReq = 1'b1; intWe = 1'b0; intAddr = 12'h007;
    @(negedge clk);
    intReq = 1'b0;
    chk("R6 internal read sees host write", 32'(intRdata), 32'h2222);

    // R7: second strobe during busy zero-wait transfer is stalled, then taken
    doReset(1'b0, 1'b1);
    intReq = 1'b1; intWe = 1'b0; intAddr = 12'h000;
    @(negedge clk);
    hostSel = 1'b1; hostStrb = 1'b1; hostRdWr = 1'b1; hostAddr = 16'h0030; hostWdata = 16'h7777;
    @(negedge clk);
    hostStrb = 1'b0; hostSel = 1'b0;
    @(negedge clk);
    hostSel = 1'b1; hostStrb = 1'b1; hostRdWr = 1'b1; hostAddr = 16'h4000; hostWdata = 16'h8888;
    repeat (3) @(negedge clk);
    chk("R7 busy while second strobe waits", 32'(hostReady), 32'd1);
    intReq = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (hostReady && lat < 50);
    chk("R7 first transfer done", 32'(hostReady), 32'd0);
    @(negedge clk);
    chk("R7 stalled strobe taken", 32'(hostReady), 32'd1);
    hostStrb = 1'b0; hostSel = 1'b0;
    lat = 0;
    while (hostReady && lat < 50) begin @(negedge clk); lat++; end
    zwAccess(1'b0, 16'h0030, 16'h0000, rd, en, lat);
    chk("R7 first write landed", 32'(rd), 32'h7777);
    zwAccess(1'b0, 16'h4000, 16'h0000, rd, en, lat);
    chk("R7 R4 second write landed", 32'(rd), 32'h8888);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule